// File: doc/BRIEF.md
# Dual-Enable Synchronous Counter with Carry

A small synchronous up-counter whose flip-flops all change together on the rising clock edge. The count moves forward only when two separate enable inputs are both high. One enable, the carry enable, also gates the carry output. The other, the parallel enable, affects counting only. This split lets a chain of stages pause locally without breaking the carry path.

Two synchronous active-low controls override counting. Clear sends the count to zero, and load copies a data word into the counter. Clear beats load, and load beats counting. Neither control depends on the enables.

A parameter picks the modulus: a full binary range, or a decade range that stops at nine. The carry output is decoded combinationally from the present count and the carry enable, so a following stage sees it in the same cycle.

Top module: `dual_enable_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 on that edge.
- R2: `clr_n` low at a rising edge makes the count 0, whatever `load_n`, `en_p`, `en_t` and `din` are.
- R3: With `clr_n` high and `load_n` low at a rising edge, the count takes the value of `din`, whatever the two enables are.
- R4: With `clr_n` and `load_n` high and both `en_p` and `en_t` high, the count rises by one per edge below the terminal value.
- R5: With `clr_n` and `load_n` high and either `en_p` or `en_t` low, the count holds its value.
- R6: The terminal value is 15 in binary mode (`DECADE`=0) and 9 in decade mode (`DECADE`=1). A counting edge taken at the terminal value returns the count to 0.
- R7: `carry_out` is high exactly when `en_t` is high and the count equals the terminal value. It follows `en_t` in the same cycle, and `en_p` has no effect on it.
- R8: In decade mode, a loaded value from 10 to 15 still rises by one on each counting edge, and 15 wraps to 0.
- R9: Clear and load take effect only at a rising edge. Between edges, a low `clr_n` or `load_n` leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Synchronous active-low clear |
| load_n | input | 1 | Synchronous active-low parallel load |
| en_p | input | 1 | Parallel count enable (no effect on carry) |
| en_t | input | 1 | Carry count enable (also gates carry) |
| din | input | WIDTH | Parallel load data |
| q | output | WIDTH | Registered count |
| carry_out | output | 1 | Terminal-count carry, combinational |

## Verification
The bench loads every starting value into a binary and a decade instance. From each start it applies all sixteen combinations of clear, load and the two enables, then compares the count and the carry against arithmetic expectations. The sweep targets cases a faulty design would get wrong:
- a load or clear that defers to the enables, or a load that wins over clear;
- a carry that ignores `en_t` or reacts to `en_p`;
- a decade counter that wraps at the wrong value, or that jams or clamps after an out-of-range load instead of climbing to 15 and rolling to 0.

Between edges, the count is checked before the edge to catch any clear or load that acts asynchronously.

// File: rtl/dec_cnt_pkg.sv
package dec_cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_op_sel.sv
module cnt_op_sel
  import dec_cnt_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  // Fixed priority: clear, then load, then count; enables only gate counting.
  always_comb begin
    if (!clr_n)             op = OP_CLEAR;
    else if (!load_n)       op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_term_detect.sv
module cnt_term_detect #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q,
  output logic             at_term
);
  localparam logic [WIDTH-1:0] TERM_DEC = WIDTH'(9);

  generate
    if (DECADE) begin : g_decade
      assign at_term = (q == TERM_DEC);
    end else begin : g_binary
      assign at_term = &q;
    end
  endgenerate
endmodule

// File: rtl/cnt_next_val.sv
module cnt_next_val
  import dec_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] din,
  input  logic             at_term,
  output logic [WIDTH-1:0] q_nxt
);
  always_comb begin
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      // Above-terminal values simply increment and roll over naturally.
      OP_COUNT: q_nxt = at_term ? '0 : q + 1'b1;
      default:  q_nxt = q;
    endcase
  end
endmodule

// File: rtl/dual_enable_counter.sv
module dual_enable_counter
  import dec_cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry_out
);
  localparam logic [WIDTH-1:0] TERM = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  cnt_op_e          op;
  logic             at_term;
  logic [WIDTH-1:0] q_nxt;

  cnt_op_sel u_sel (
    .clr_n (clr_n),
    .load_n(load_n),
    .en_p  (en_p),
    .en_t  (en_t),
    .op    (op)
  );

  cnt_term_detect #(.WIDTH(WIDTH), .DECADE(DECADE)) u_term (
    .q      (q),
    .at_term(at_term)
  );

  cnt_next_val #(.WIDTH(WIDTH)) u_next (
    .op     (op),
    .q      (q),
    .din    (din),
    .at_term(at_term),
    .q_nxt  (q_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

  // Combinational carry so a following stage sees it in the same cycle.
  assign carry_out = en_t & at_term;

  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_n |=> (q == '0));

  assert_load_R3: assert property (@(posedge clk) disable iff (rst)
    (clr_n && !load_n) |=> (q == $past(din)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t && q != TERM) |=> (q == WIDTH'($past(q) + 1'b1)));

  assert_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (clr_n && load_n && en_p && en_t && q == TERM) |=> (q == '0));

  assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> (en_t && q == TERM));
endmodule

// File: tb/dual_enable_counter_tb.sv
module dual_enable_counter_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] q_b, q_d;
  logic         co_b, co_d;
  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_b, exp_d;

  always #10 clk = ~clk;

  dual_enable_counter #(.WIDTH(W), .DECADE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q_b), .carry_out(co_b));

  dual_enable_counter #(.WIDTH(W), .DECADE(1'b1)) u_dut_dec (
    .clk(clk), .rst(rst), .clr_n(clr_n), .load_n(load_n), .en_p(en_p),
    .en_t(en_t), .din(din), .q(q_d), .carry_out(co_d));

  function automatic logic [W-1:0] model(input logic [W-1:0] cur, input int term);
    if (!clr_n) return '0;
    if (!load_n) return din;
    if (en_p && en_t) return (int'(cur) == term) ? '0 : W'((int'(cur) + 1) % 16);
    return cur;
  endfunction

  function automatic string tag(input logic [W-1:0] cur, input int term, input bit dec);
    if (!clr_n) return "R2";
    if (!load_n) return "R3";
    if (!(en_p && en_t)) return "R5";
    if (int'(cur) == term) return "R6";
    if (dec && cur > 4'd9) return "R8";
    return "R4";
  endfunction

  task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  // Drive at negedge, check carry and pre-edge count, take one edge, check count.
  task automatic step(input logic c, input logic l, input logic p, input logic t, input logic [W-1:0] d);
    string tb_s, td_s;
    clr_n = c; load_n = l; en_p = p; en_t = t; din = d;
    #2;
    chk("R7", W'(co_b), W'(t && exp_b == 4'd15), "binary carry");
    chk("R7", W'(co_d), W'(t && exp_d == 4'd9), "decade carry");
    chk("R9", q_b, exp_b, "binary count before edge");
    tb_s = tag(exp_b, 15, 1'b0);
    td_s = tag(exp_d, 9, 1'b1);
    exp_b = model(exp_b, 15);
    exp_d = model(exp_d, 9);
    @(negedge clk);
    chk(tb_s, q_b, exp_b, "binary count");
    chk(td_s, q_d, exp_d, "decade count");
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    din = 4'd7; load_n = 1'b1;
    repeat (3) @(negedge clk);
    exp_b = '0; exp_d = '0;
    chk("R1", q_b, 4'd0, "binary reset");
    chk("R1", q_d, 4'd0, "decade reset");
    rst = 1'b0;
    for (int s = 0; s < 16; s++) begin
      for (int ctl = 0; ctl < 16; ctl++) begin
        step(1'b1, 1'b0, ctl[0], ctl[1], W'(s));
        step(ctl[3], ctl[2], ctl[1], ctl[0], W'((s * 7 + ctl * 5 + 3) % 16));
      end
    end
    // R8: decade instance loaded with 12 climbs through 15 and rolls to 0.
    step(1'b1, 1'b0, 1'b1, 1'b1, 4'd12);
    for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
    chk("R8", q_d, 4'd2, "decade after out-of-range run");
    // R6: long free run through several wraps.
    for (int k = 0; k < 40; k++) step(1'b1, 1'b1, 1'b1, 1'b1, 4'd5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule